// File: doc/BRIEF.md
# Cascaded Two-Stage Tick Interrupt Timer

This block produces a slow periodic interrupt from a fast system clock. A prescaler turns the system clock into a periodic tick enable, nominally 64 kHz. That tick drives a 16-bit first stage, which counts down and reloads from its divisor. Each reload of the first stage steps a 16-bit second stage. When a step finds the second stage at zero, the block raises a one-clock interrupt request and the second stage wraps around through 65536.

Software programs the block over a byte-wide bus. Each counter takes its 16-bit value as two writes, low byte first. Writing only the low byte of the first stage freezes the engine. The high byte reloads the first stage and restarts counting.

A byte-wide read returns the live value of a counter, low byte first. The high byte is captured at the moment the low byte is read. Two copies of the block feed different interrupt controller lines, so the line is chosen by parameter.

Top module: `cascade_tick_timer`

## Requirements
- R1: A synchronous reset clears both stage counts, the spare value and the mode byte, stops the engine, holds `irq_lines` at zero and clears every write and read byte toggle, so the next access to any counter is its low byte.
- R2: While running, the first stage (address 0) decrements once per tick, and a tick occurs every `TICK_DIV` clocks counted from the start edge. On the tick where the count is 1 or less, the stage reloads its divisor instead, so divisors 0 and 1 both reload on every tick.
- R3: On each first-stage reload, the second stage (address 1) is tested before it changes. If it is zero, an interrupt pulse one clock wide is raised and the stage becomes 0xFFFF. Otherwise it decrements. With divisor D (≥1) and second-stage value N, the pulse appears `TICK_DIV*D*(N+1)` clocks after the edge that wrote the first stage's high byte.
- R4: Writing the low byte of the first stage stops the engine and freezes both counts. Only the following high-byte write restarts it, which loads the first stage and restarts the prescaler.
- R5: Addresses 0, 1 and 2 select first stage, second stage and spare counter. Each takes alternating low/high byte writes tracked by a per-counter toggle, and the value takes effect on the high byte.
- R6: A read at addresses 0–2 returns bits 7:0 of the live value, then on the next read bits 15:8 as they were captured at the low-byte read.
- R7: Address 3 is a mode byte that is written and read back directly but does not change counting or interrupt timing.
- R8: Loading the second stage or the spare counter neither starts nor stops the engine, and the spare value has no effect on timing.
- R9: Only bit `IRQ_LINE` of `irq_lines` is ever driven high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe; advances the read toggle |
| addr | input | 2 | 0 first stage, 1 second stage, 2 spare, 3 mode |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte for the current address |
| irq_lines | output | IRQ_WIDTH | Interrupt request vector; pulse on bit IRQ_LINE |

## Verification
The embedded properties assume that reset is asserted from time zero. They also assume that a second-stage load never lands on the same edge as a first-stage reload. The wrap check would otherwise see a written value where it expects 0xFFFF.

The stimulus loads the second stage only while the engine is stopped, or before the first-stage high byte is written. It also drives the bus only between clock edges. Interrupt timing is therefore decided by the counters alone.

// File: rtl/cascade_tick_timer.sv
module cascade_tick_timer #(
  parameter int TICK_DIV  = 781,
  parameter int IRQ_WIDTH = 8,
  parameter int IRQ_LINE  = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [1:0]           addr,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  output logic [IRQ_WIDTH-1:0] irq_lines
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre;
  logic          run, irq_q;
  logic [15:0]   div_a, cnt_a, cnt_b, spare, live;
  logic [7:0]    mode_q, hold;
  logic [7:0]    lo_stage [4];
  logic [3:0]    wtog, rtog;
  logic          tick, reload, is_mode;

  assign tick    = run && (pre == PRE_LAST);
  assign reload  = tick && (cnt_a <= 16'd1);
  assign is_mode = (addr == 2'd3);

  always_comb begin
    case (addr)
      2'd0:    live = cnt_a;
      2'd1:    live = cnt_b;
      2'd2:    live = spare;
      default: live = {8'h00, mode_q};
    endcase
  end

  assign rdata = is_mode ? mode_q : (rtog[addr] ? hold : live[7:0]);

  always_comb begin
    irq_lines = '0;
    irq_lines[IRQ_LINE] = irq_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre    <= '0;
      run    <= 1'b0;
      irq_q  <= 1'b0;
      div_a  <= '0;
      cnt_a  <= '0;
      cnt_b  <= '0;
      spare  <= '0;
      mode_q <= '0;
      hold   <= '0;
      wtog   <= '0;
      rtog   <= '0;
      for (int i = 0; i < 4; i++) lo_stage[i] <= '0;
    end else begin
      irq_q <= 1'b0;
      if (run) pre <= tick ? '0 : pre + 1'b1;

      if (tick) begin
        if (reload) begin
          cnt_a <= div_a;
          if (cnt_b == 16'd0) begin
            irq_q <= 1'b1;
            cnt_b <= 16'hFFFF;
          end else begin
            cnt_b <= cnt_b - 16'd1;
          end
        end else begin
          cnt_a <= cnt_a - 16'd1;
        end
      end

      if (wr_en) begin
        if (is_mode) begin
          mode_q <= wdata;
        end else if (!wtog[addr]) begin
          lo_stage[addr] <= wdata;
          wtog[addr]     <= 1'b1;
          if (addr == 2'd0) run <= 1'b0;
        end else begin
          wtog[addr] <= 1'b0;
          case (addr)
            2'd0: begin
              div_a <= {wdata, lo_stage[addr]};
              cnt_a <= {wdata, lo_stage[addr]};
              run   <= 1'b1;
              pre   <= '0;
            end
            2'd1:    cnt_b <= {wdata, lo_stage[addr]};
            default: spare <= {wdata, lo_stage[addr]};
          endcase
        end
      end

      if (rd_en && !is_mode) begin
        if (!rtog[addr]) begin
          hold       <= live[15:8];
          rtog[addr] <= 1'b1;
        end else begin
          rtog[addr] <= 1'b0;
        end
      end
    end
  end

  assert_freeze_a_R4: assert property (@(posedge clk) disable iff (rst)
    (!run && !(wr_en && addr == 2'd0)) |=> $stable(cnt_a));

  assert_freeze_b_R4: assert property (@(posedge clk) disable iff (rst)
    (!run && !(wr_en && addr == 2'd1)) |=> $stable(cnt_b));

  assert_low_byte_stops_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd0 && !wtog[0]) |=> !run);

  assert_irq_from_tick_R3: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(tick));

  assert_wrap_value_R3: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !$past(wr_en && addr == 2'd1)) |-> (cnt_b == 16'hFFFF));

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_a <= div_a));
endmodule

// File: tb/sim_cascade_tick_timer.sv
module sim_cascade_tick_timer;
  localparam int TDIV = 4;
  localparam int LINE = 6;
  localparam int WID  = 8;
  localparam int NVEC = 6;
  // {first-stage divisor, second-stage value}
  localparam logic [31:0] VEC [NVEC] = '{32'h0002_0000, 32'h0003_0002, 32'h0001_0003,
                                         32'h0000_0002, 32'h0005_0001, 32'h000A_0004};

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [WID-1:0] irq_lines;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  cascade_tick_timer #(.TICK_DIV(TDIV), .IRQ_WIDTH(WID), .IRQ_LINE(LINE)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_lines(irq_lines));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic load16(input logic [1:0] a, input logic [15:0] v);
    wr(a, v[7:0]); wr(a, v[15:8]);
  endtask

  task automatic rd16(input logic [1:0] a, output logic [15:0] v);
    addr = a; rd_en = 1'b1;
    #1 v[7:0] = rdata;
    @(negedge clk); #1 v[15:8] = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    for (int k = 1; k <= 5000; k++) begin
      @(negedge clk);
      if (|irq_lines) begin n = k; break; end
    end
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v, v2;
    int n, exp, d;
    do_reset();

    // R1 reset state
    rd16(2'd0, v); check(v == 16'h0000, "R1 first stage after reset", v, 0);
    rd16(2'd1, v); check(v == 16'h0000, "R1 second stage after reset", v, 0);
    check(irq_lines == '0, "R1 irq low after reset", irq_lines, 0);
    wr(2'd1, 8'h55);
    do_reset();
    load16(2'd1, 16'h0007);
    rd16(2'd1, v); check(v == 16'h0007, "R1 toggle cleared by reset", v, 7);

    // R2/R3/R9 vector table
    for (int i = 0; i < NVEC; i++) begin
      do_reset();
      load16(2'd1, VEC[i][15:0]);
      load16(2'd0, VEC[i][31:16]);
      d = (VEC[i][31:16] == 0) ? 1 : int'(VEC[i][31:16]);
      exp = TDIV * d * (int'(VEC[i][15:0]) + 1);
      wait_irq(n);
      check(n == exp, "R3 R2 interrupt period", n, exp);
      check(irq_lines == WID'(1 << LINE), "R9 only selected line", irq_lines, 1 << LINE);
      @(negedge clk);
      check(irq_lines == '0, "R3 one-clock pulse", irq_lines, 0);
    end

    // R3 wrap to 0xFFFF
    do_reset();
    load16(2'd1, 16'h0000);
    load16(2'd0, 16'h0002);
    wait_irq(n);
    rd16(2'd1, v); check(v == 16'hFFFF, "R3 second stage wraps", v, 16'hFFFF);

    // R6 live read with captured high byte
    do_reset();
    load16(2'd0, 16'h0100);
    repeat (40) @(negedge clk);
    rd16(2'd0, v); check(v == 16'h00F6, "R6 live first stage read", v, 16'h00F6);

    // R4/R8 stop on low byte, second stage load keeps engine stopped
    do_reset();
    load16(2'd1, 16'h0005);
    load16(2'd0, 16'h0003);
    repeat (10) @(negedge clk);
    wr(2'd0, 8'h03);
    rd16(2'd1, v);
    rd16(2'd0, v2);
    repeat (40) @(negedge clk);
    begin
      logic [15:0] b2, a2;
      rd16(2'd1, b2); check(b2 == v, "R4 second stage frozen", b2, v);
      rd16(2'd0, a2); check(a2 == v2, "R4 first stage frozen", a2, v2);
      check(irq_lines == '0, "R4 no irq while stopped", irq_lines, 0);
      load16(2'd1, 16'h0001);
      repeat (40) @(negedge clk);
      rd16(2'd0, a2); check(a2 == v2, "R8 second stage load does not start", a2, v2);
      rd16(2'd1, b2); check(b2 == 16'h0001, "R5 second stage loaded", b2, 1);
    end
    wr(2'd0, 8'h00);
    wait_irq(n);
    check(n == TDIV * 3 * 2, "R4 high byte restarts", n, TDIV * 3 * 2);

    // R7/R8 mode byte and spare counter
    do_reset();
    wr(2'd3, 8'h92);
    addr = 2'd3; #1 check(rdata == 8'h92, "R7 mode readback", rdata, 8'h92);
    load16(2'd2, 16'hBEEF);
    rd16(2'd2, v); check(v == 16'hBEEF, "R8 spare readback", v, 16'hBEEF);
    load16(2'd1, 16'h0001);
    load16(2'd0, 16'h0002);
    wait_irq(n);
    check(n == TDIV * 2 * 2, "R7 R8 timing unaffected", n, TDIV * 2 * 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule